// File: doc/BRIEF.md
# Dual-Function Bus Request Arbiter

This block lets two internal bus-master functions, a video engine and an audio engine, share one external PCI request/grant pair. It folds the two internal requests into the single active-low REQ# pin and hands the external grant to exactly one of the two functions. Video is the default owner: it holds the grant whenever audio is not asking, so the grant parks on video while both are idle. Audio wins whenever it is asking at the moment the grant is routed. Once a transaction is under way on the bus, the routing does not move.

Two enables work around host chipsets that break the bus rules. The lock enable freezes the routing choice when the external grant arrives. REQ# then follows only the chosen function's request, so the chosen initiator can drop REQ# together with FRAME#. The lock holds until the transaction finishes (FRAME# and IRDY# both idle), or until the grant is withdrawn before any FRAME#. The gate enable passes no grant inward unless REQ# is asserted at the pin. This blocks a transaction that starts as the grant goes away, and it gives up bus parking. The two enables may be used together. The control signals here carry no data, so there is no valid/ready interface and no back-pressure.

Top module: `pciarb_top`

## Requirements
- R1: While reset is held and on the first edges after it, `pci_req_n_o` is 1 and both internal grants are 0.
- R2: With lock disabled, `pci_req_n_o` equals the inverse of (video request OR audio request) as sampled on the previous rising clock edge.
- R3: A grant is passed inward only while the registered GNT# (sampled low on the previous edge) is active. Outside a transaction it goes to audio when `aud_req_i` is 1 and to video otherwise. Video therefore holds the parked grant.
- R4: Audio has priority. If audio raises its request after video but before GNT# arrives, audio receives the grant.
- R5: While the registered FRAME# or IRDY# is active (low), the routing stays as it was, so the other function cannot take over a running transaction.
- R6: With lock enabled, the first edge that sees GNT# active latches the current routing. From then on, REQ# is driven only from the selected function's request, whatever FRAME# does.
- R7: While locked, the non-selected function's request cannot keep `pci_req_n_o` low. REQ# goes high one cycle after the selected function drops its request.
- R8: The lock is released once a transaction that it saw has ended with FRAME# and IRDY# both high. It is also released if GNT# is removed before any FRAME# was seen. After release, REQ# is the OR of both requests again.
- R9: With gating enabled, no internal grant is asserted while `pci_req_n_o` is 1, even when GNT# is active. This disables parking.
- R10: With both enables set, gating applies on top of the locked routing.
- R11: At most one internal grant is 1 in any cycle, in every mode combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| vid_req_i | input | 1 | Video function bus request, active high |
| aud_req_i | input | 1 | Audio function bus request, active high |
| pci_gnt_n_i | input | 1 | External grant, active low |
| pci_frame_n_i | input | 1 | Bus FRAME#, active low |
| pci_irdy_n_i | input | 1 | Bus IRDY#, active low |
| lock_en_i | input | 1 | Enables routing lock from grant until bus idle |
| gate_en_i | input | 1 | Enables grant suppression while REQ# is inactive |
| pci_req_n_o | output | 1 | External request, active low, registered |
| vid_gnt_o | output | 1 | Grant to the video function, active high |
| aud_gnt_o | output | 1 | Grant to the audio function, active high |

## Verification
The hardest case to reach is the one in R7. It needs the lock to be taken with video selected, audio to raise its request behind it, and video to drop its request on the cycle FRAME# falls. Only then does REQ# have to go high while a request is still pending. The stimulus reaches it with a directed sequence: enable lock, grant video, raise audio, assert FRAME# while dropping video, then bring FRAME# and IRDY# back to idle so that release (R8) hands REQ# to audio. Randomized cycles across all four mode combinations then check grant exclusivity and gating against a cycle model.

// File: rtl/pciarb_pkg.sv
package pciarb_pkg;
  typedef enum logic {
    OWN_VID = 1'b0,
    OWN_AUD = 1'b1
  } owner_e;

  localparam int unsigned PIN_GNT   = 0;
  localparam int unsigned PIN_FRAME = 1;
  localparam int unsigned PIN_IRDY  = 2;
  localparam int unsigned PIN_COUNT = 3;
endpackage

// File: rtl/pciarb_pin_sync.sv
module pciarb_pin_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_n_i,
  output logic [WIDTH-1:0] act_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_o[b] <= 1'b0;
      else        act_o[b] <= ~pin_n_i[b];
    end
  end
endmodule

// File: rtl/pciarb_lock_ctrl.sv
module pciarb_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_en_i,
  input  logic gnt_i,
  input  logic frame_i,
  input  logic irdy_i,
  output logic locked_o
);
  logic seen_q;
  logic release_now;

  assign release_now = seen_q ? (!frame_i && !irdy_i) : (!gnt_i && !frame_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_o <= 1'b0;
      seen_q   <= 1'b0;
    end else if (!locked_o) begin
      locked_o <= lock_en_i && gnt_i;
      seen_q   <= 1'b0;
    end else if (release_now) begin
      locked_o <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      seen_q   <= seen_q | frame_i;
    end
  end

  p_lock_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_o && lock_en_i && gnt_i) |=> locked_o);

  p_lock_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && seen_q && !frame_i && !irdy_i) |=> !locked_o);
endmodule

// File: rtl/pciarb_route.sv
module pciarb_route
  import pciarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   locked_i,
  input  logic   busy_i,
  input  logic   vid_req_i,
  input  logic   aud_req_i,
  output owner_e route_o,
  output logic   req_merged_o
);
  owner_e sel_q;
  logic   hold;

  assign hold    = locked_i | busy_i;
  assign route_o = hold ? sel_q : (aud_req_i ? OWN_AUD : OWN_VID);

  always_comb begin
    if (locked_i) req_merged_o = (route_o == OWN_AUD) ? aud_req_i : vid_req_i;
    else          req_merged_o = vid_req_i | aud_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= OWN_VID;
    else        sel_q <= route_o;
  end

  p_hold_route_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> $stable(route_o));
endmodule

// File: rtl/pciarb_top.sv
module pciarb_top
  import pciarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vid_req_i,
  input  logic aud_req_i,
  input  logic pci_gnt_n_i,
  input  logic pci_frame_n_i,
  input  logic pci_irdy_n_i,
  input  logic lock_en_i,
  input  logic gate_en_i,
  output logic pci_req_n_o,
  output logic vid_gnt_o,
  output logic aud_gnt_o
);
  logic [PIN_COUNT-1:0] pins_n;
  logic [PIN_COUNT-1:0] pins_act;
  logic   locked;
  logic   req_merged;
  logic   gnt_ok;
  owner_e route;

  assign pins_n[PIN_GNT]   = pci_gnt_n_i;
  assign pins_n[PIN_FRAME] = pci_frame_n_i;
  assign pins_n[PIN_IRDY]  = pci_irdy_n_i;

  pciarb_pin_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n_i(pins_n),
    .act_o  (pins_act)
  );

  pciarb_lock_ctrl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_en_i(lock_en_i),
    .gnt_i    (pins_act[PIN_GNT]),
    .frame_i  (pins_act[PIN_FRAME]),
    .irdy_i   (pins_act[PIN_IRDY]),
    .locked_o (locked)
  );

  pciarb_route u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .locked_i    (locked),
    .busy_i      (pins_act[PIN_FRAME] | pins_act[PIN_IRDY]),
    .vid_req_i   (vid_req_i),
    .aud_req_i   (aud_req_i),
    .route_o     (route),
    .req_merged_o(req_merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pci_req_n_o <= 1'b1;
    else        pci_req_n_o <= ~req_merged;
  end

  assign gnt_ok    = pins_act[PIN_GNT] && (!gate_en_i || !pci_req_n_o);
  assign vid_gnt_o = gnt_ok && (route == OWN_VID);
  assign aud_gnt_o = gnt_ok && (route == OWN_AUD);

  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(vid_gnt_o && aud_gnt_o));

  p_gate_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_i && pci_req_n_o) |-> (!vid_gnt_o && !aud_gnt_o));

  p_req_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(locked) && !locked) |-> (pci_req_n_o == !($past(vid_req_i) || $past(aud_req_i))));

  p_gnt_needs_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pci_gnt_n_i) |-> (!vid_gnt_o && !aud_gnt_o));
endmodule

// File: tb/pciarb_top_tb_top.sv
`timescale 1ns/1ps
module pciarb_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vid_req = 1'b0, aud_req = 1'b0;
  logic gnt_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1;
  logic lock_en = 1'b0, gate_en = 1'b0;
  logic req_n, vid_gnt, aud_gnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  req_n;
    logic  vg;
    logic  ag;
    string tag;
  } exp_t;
  exp_t sb[$];

  // model state
  logic m_gnt = 0, m_frame = 0, m_irdy = 0, m_locked = 0, m_seen = 0, m_sel = 0, m_reqn = 1;
  string cur_tag = "R2";

  always #5 clk = ~clk;

  pciarb_top dut_i (
    .clk(clk), .rst_n(rst_n), .vid_req_i(vid_req), .aud_req_i(aud_req),
    .pci_gnt_n_i(gnt_n), .pci_frame_n_i(frame_n), .pci_irdy_n_i(irdy_n),
    .lock_en_i(lock_en), .gate_en_i(gate_en),
    .pci_req_n_o(req_n), .vid_gnt_o(vid_gnt), .aud_gnt_o(aud_gnt)
  );

  task automatic check(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic m_route();
    return (m_locked | m_frame | m_irdy) ? m_sel : aud_req;
  endfunction

  // driver: advance model on the edge, push expected outputs
  task automatic cyc();
    logic r_old, reqc, ok;
    exp_t e;
    @(posedge clk);
    r_old = m_route();
    reqc  = m_locked ? (r_old ? aud_req : vid_req) : (vid_req | aud_req);
    m_sel  = r_old;
    m_reqn = ~reqc;
    if (!m_locked) begin
      m_locked = lock_en & m_gnt;
      m_seen   = 1'b0;
    end else if (m_seen ? (!m_frame && !m_irdy) : (!m_gnt && !m_frame)) begin
      m_locked = 1'b0;
      m_seen   = 1'b0;
    end else begin
      m_seen = m_seen | m_frame;
    end
    m_gnt = ~gnt_n; m_frame = ~frame_n; m_irdy = ~irdy_n;
    #1;
    ok = m_gnt & (!gate_en | !m_reqn);
    e.req_n = m_reqn;
    e.vg = ok & !m_route();
    e.ag = ok & m_route();
    e.tag = cur_tag;
    sb.push_back(e);
    #4;
  endtask

  // monitor
  always @(posedge clk) begin
    #3;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, req_n, e.req_n, "pci_req_n");
      check(e.tag, vid_gnt, e.vg, "vid_gnt");
      check(e.tag, aud_gnt, e.ag, "aud_gnt");
      check("R11", vid_gnt & aud_gnt, 1'b0, "grant exclusivity");
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1", req_n, 1'b1, "req_n in reset");
    check("R1", vid_gnt | aud_gnt, 1'b0, "grants in reset");
    @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    gnt_n = 1'b0;
    cyc(); cyc();
    gnt_n = 1'b1;
    cyc();

    // R2: merge of requests
    cur_tag = "R2";
    vid_req = 1; cyc();
    vid_req = 0; aud_req = 1; cyc();
    vid_req = 1; cyc();
    vid_req = 0; aud_req = 0; cyc(); cyc();
    #0 check("R2", req_n, 1'b1, "idle req_n directed");

    // R3: parking on video with no requests
    cur_tag = "R3";
    gnt_n = 0; cyc(); cyc();
    check("R3", vid_gnt, 1'b1, "parked video grant directed");
    aud_req = 1; #1;
    check("R3", aud_gnt, 1'b1, "audio steered directed");
    cyc();
    gnt_n = 1; aud_req = 0; cyc(); cyc();

    // R4: audio raised after video, before grant
    cur_tag = "R4";
    vid_req = 1; cyc();
    aud_req = 1; cyc();
    gnt_n = 0; cyc();
    check("R4", aud_gnt, 1'b1, "audio wins directed");
    gnt_n = 1; aud_req = 0; vid_req = 0; cyc(); cyc();

    // R5: no preemption during a transaction
    cur_tag = "R5";
    vid_req = 1; gnt_n = 0; cyc();
    frame_n = 0; vid_req = 0; cyc();
    aud_req = 1; cyc();
    check("R5", vid_gnt, 1'b1, "video keeps bus directed");
    frame_n = 1; irdy_n = 0; cyc();
    irdy_n = 1; gnt_n = 1; cyc(); cyc();
    aud_req = 0; cyc(); cyc();

    // R6/R7/R8: locked routing
    cur_tag = "R6";
    lock_en = 1;
    vid_req = 1; cyc();
    gnt_n = 0; cyc(); cyc();
    aud_req = 1; cyc(); cyc();
    check("R6", vid_gnt, 1'b1, "lock holds video directed");
    cur_tag = "R7";
    frame_n = 0; vid_req = 0; gnt_n = 1; cyc(); cyc();
    check("R7", req_n, 1'b1, "unselected audio cannot hold req directed");
    cur_tag = "R8";
    frame_n = 1; irdy_n = 0; cyc();
    irdy_n = 1; cyc(); cyc(); cyc();
    check("R8", req_n, 1'b0, "after release audio drives req directed");
    // grant withdrawn before FRAME
    gnt_n = 0; cyc(); cyc();
    gnt_n = 1; cyc(); cyc(); cyc();
    aud_req = 0; cyc(); cyc();

    // R9: grant gating
    cur_tag = "R9";
    lock_en = 0; gate_en = 1;
    gnt_n = 0; cyc(); cyc();
    check("R9", vid_gnt | aud_gnt, 1'b0, "no grant without request directed");
    vid_req = 1; cyc(); cyc();
    check("R9", vid_gnt, 1'b1, "grant with request directed");
    vid_req = 0; gnt_n = 1; cyc(); cyc();

    // R10: both modes, then randomized mix
    cur_tag = "R10";
    lock_en = 1;
    aud_req = 1; cyc();
    gnt_n = 0; cyc(); cyc();
    check("R10", aud_gnt, 1'b1, "locked audio gated grant directed");
    frame_n = 0; aud_req = 0; vid_req = 1; cyc(); cyc();
    frame_n = 1; gnt_n = 1; cyc(); cyc(); cyc();
    vid_req = 0; cyc(); cyc();

    cur_tag = "R11";
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) begin
        lock_en = (i / 500) % 2;
        gate_en = (i / 1000) % 2;
      end
      vid_req = $urandom_range(0, 1);
      aud_req = $urandom_range(0, 2) == 0;
      gnt_n   = $urandom_range(0, 2) != 0;
      frame_n = $urandom_range(0, 3) != 0;
      irdy_n  = $urandom_range(0, 3) != 0;
      cyc();
    end
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule